// File: doc/BRIEF.md
# Store Queue Forwarding Search

This block keeps the in-flight stores of a load/store unit in a circular entry array and answers forwarding searches from a pipelined load unit. Each store entry holds a double-word virtual address, a double-word physical address, an 8-lane byte mask and 64 bits of data. Entries are allocated at the tail, retired at the head and all dropped at once by a flush. Pointers carry one extra wrap bit. The address and the data of a store arrive on two separate write ports, at any time after the entry is allocated.

A load presents its virtual and physical address, its 8-lane byte mask and a vector with one bit per entry that marks the stores older than the load. The load unit computes this vector a stage early, so the search does no pointer arithmetic. The block searches on the virtual address. For each requested byte lane it selects the youngest older store that covers the lane. One cycle later it returns a fast lane hit mask and a data-not-ready flag. One cycle after that it returns the final lane mask, the forwarded bytes, and three conditions with store indices where they apply: an older store whose data is missing, an older store whose address is missing, and a disagreement between the virtual-address match and the physical-address match. The last condition asks the core to flush.

Top module: `stfwd_queue`

## Requirements
- R1: While reset is asserted, both pointers read zero and neither response stage is valid.
- R2: An allocation advances the tail pointer by one and is ignored when DEPTH entries are occupied. A dequeue advances the head pointer by one and is ignored when the queue is empty. Both pointers are DEPTH*2 modulo counters, and bit IDX_W of each is the wrap bit.
- R3: A flush clears every entry and returns both pointers to zero, which overrides allocation and dequeue in the same cycle. A load after a flush finds no store.
- R4: An address write with size code 0, 1, 2 or 3 gives the entry the lane mask 8'h01, 8'h03, 8'h0F or 8'hFF, shifted left by physical address bits [2:0]. A load presented in the cycle after the write request does not see the new address and mask. A load presented two cycles after the request does see them.
- R5: A data write spreads its low bytes by size code: byte to all 8 lanes, halfword to 4 pairs, word to 2 halves, double unchanged. It takes effect for loads presented in the next cycle.
- R6: s1_valid_o rises in the cycle after a load request. s1_hit_o then shows the lanes that a forwarding store with written data supplies.
- R7: s2_valid_o follows two cycles after the request. It carries the same lane mask in s2_hit_o, and s2_data_o holds the forwarded bytes, with zero in every lane whose hit bit is clear.
- R8: An entry is a candidate when it is valid, marked older, has its address written, matches the load's virtual address above bit 3, and shares at least one requested lane. For each requested lane the youngest candidate covering it (age counted from the head) decides the lane. The lane hits only if that store's data is written.
- R9: When any candidate lacks its data, the data-not-ready flag is raised in both stages. s2_data_wait_idx_o gives the youngest such entry, and is zero when the flag is clear.
- R10: When any valid older entry has no address yet, s2_addr_wait_o is raised and s2_addr_wait_idx_o gives the youngest such entry, which is zero otherwise.
- R11: s2_mismatch_o is raised when the per-entry candidate set found by the virtual address differs from the set found by the physical address under the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Drop all entries and reset pointers |
| alloc_i | input | 1 | Allocate the entry at the tail |
| deq_i | input | 1 | Retire the entry at the head |
| head_ptr_o | output | IDX_W+1 | Head pointer with wrap bit |
| tail_ptr_o | output | IDX_W+1 | Tail pointer with wrap bit |
| aw_valid_i | input | 1 | Store address write request |
| aw_idx_i | input | IDX_W | Entry written by the address port |
| aw_vaddr_i | input | VA_W | Store virtual address |
| aw_paddr_i | input | PA_W | Store physical address; bits [2:0] place the mask |
| aw_size_i | input | 2 | Store size code |
| dw_valid_i | input | 1 | Store data write request |
| dw_idx_i | input | IDX_W | Entry written by the data port |
| dw_data_i | input | 64 | Store data, low-aligned |
| dw_size_i | input | 2 | Size code used to spread the data |
| ld_valid_i | input | 1 | Load search request |
| ld_vaddr_i | input | VA_W | Load virtual address |
| ld_paddr_i | input | PA_W | Load physical address |
| ld_mask_i | input | 8 | Requested byte lanes |
| ld_older_i | input | DEPTH | One bit per entry marking stores older than the load |
| s1_valid_o | output | 1 | Fast response valid |
| s1_hit_o | output | 8 | Fast lane hit mask |
| s1_data_wait_o | output | 1 | Fast data-not-ready flag |
| s2_valid_o | output | 1 | Full response valid |
| s2_hit_o | output | 8 | Lane hit mask |
| s2_data_o | output | 64 | Forwarded bytes |
| s2_data_wait_o | output | 1 | Data-not-ready flag |
| s2_data_wait_idx_o | output | IDX_W | Entry whose data is awaited |
| s2_addr_wait_o | output | 1 | Address-not-ready flag |
| s2_addr_wait_idx_o | output | IDX_W | Entry whose address is awaited |
| s2_mismatch_o | output | 1 | Virtual and physical match sets differ |

## Verification
The pointers change on the edge that samples allocate, dequeue or flush. An address write becomes visible to a load presented two edges after the request, and a data write to a load presented one edge after. Fast results are due one edge after the load, and full results two edges after. The bench keeps a behavioural model whose state always matches the state the design holds before the coming edge. It computes each load's answer from that state when it drives the load. It then holds the answer in a two-slot delay line, compares stage 1 at the next falling edge and stage 2 at the one after, and checks the pointers at every falling edge.

// File: rtl/stfwd_pkg.sv
package stfwd_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } st_size_e;

  // lane mask covered by a store of the given size at the given offset
  function automatic logic [7:0] lane_mask(input logic [1:0] sz, input logic [2:0] off);
    logic [7:0] base;
    case (st_size_e'(sz))
      SZ_BYTE: base = 8'h01;
      SZ_HALF: base = 8'h03;
      SZ_WORD: base = 8'h0f;
      default: base = 8'hff;
    endcase
    return base << off;
  endfunction

  // replicate low-aligned store data across the double word
  function automatic logic [63:0] spread(input logic [63:0] d, input logic [1:0] sz);
    case (st_size_e'(sz))
      SZ_BYTE: return {8{d[7:0]}};
      SZ_HALF: return {4{d[15:0]}};
      SZ_WORD: return {2{d[31:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [63:0] lanes_to_bits(input logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

endpackage

// File: rtl/stfwd_entries.sv
module stfwd_entries
  import stfwd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int VA_W  = 16,
  parameter int PA_W  = 20,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int VDW_W = VA_W - 3,
  localparam int PDW_W = PA_W - 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush_i,
  input  logic                             alloc_i,
  input  logic                             deq_i,
  input  logic                             aw_valid_i,
  input  logic [IDX_W-1:0]                 aw_idx_i,
  input  logic [VA_W-1:0]                  aw_vaddr_i,
  input  logic [PA_W-1:0]                  aw_paddr_i,
  input  logic [1:0]                       aw_size_i,
  input  logic                             dw_valid_i,
  input  logic [IDX_W-1:0]                 dw_idx_i,
  input  logic [63:0]                      dw_data_i,
  input  logic [1:0]                       dw_size_i,
  output logic [PTR_W-1:0]                 head_o,
  output logic [PTR_W-1:0]                 tail_o,
  output logic [DEPTH-1:0]                 valid_o,
  output logic [DEPTH-1:0]                 aok_o,
  output logic [DEPTH-1:0]                 dok_o,
  output logic [DEPTH-1:0][VDW_W-1:0]      vdw_o,
  output logic [DEPTH-1:0][PDW_W-1:0]      pdw_o,
  output logic [DEPTH-1:0][7:0]            mask_o,
  output logic [DEPTH-1:0][63:0]           data_o
);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d, occ;
  logic [DEPTH-1:0] valid_q, valid_d, aok_q, aok_d, dok_q, dok_d;
  logic             full, empty, do_alloc, do_deq;
  logic [IDX_W-1:0] head_idx, tail_idx;

  // address write pipeline register: mask lands one cycle after the request
  logic             aw_v_q, aw_v_d;
  logic [IDX_W-1:0] aw_idx_q;
  logic [VDW_W-1:0] aw_vdw_q;
  logic [PDW_W-1:0] aw_pdw_q;
  logic [7:0]       aw_mask_q;

  logic [DEPTH-1:0][VDW_W-1:0] vdw_q;
  logic [DEPTH-1:0][PDW_W-1:0] pdw_q;
  logic [DEPTH-1:0][7:0]       mask_q;
  logic [DEPTH-1:0][63:0]      data_q;

  always_comb begin
    head_idx = head_q[IDX_W-1:0];
    tail_idx = tail_q[IDX_W-1:0];
    occ      = tail_q - head_q;
    full     = (occ == PTR_W'(DEPTH));
    empty    = (occ == '0);
    do_alloc = alloc_i && !full && !flush_i;
    do_deq   = deq_i && !empty && !flush_i;
  end

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    valid_d = valid_q;
    aok_d   = aok_q;
    dok_d   = dok_q;
    aw_v_d  = aw_valid_i;
    if (do_deq) begin
      valid_d[head_idx] = 1'b0;
      head_d            = head_q + PTR_W'(1);
    end
    if (aw_v_q)     aok_d[aw_idx_q] = 1'b1;
    if (dw_valid_i) dok_d[dw_idx_i] = 1'b1;
    if (do_alloc) begin
      valid_d[tail_idx] = 1'b1;
      aok_d[tail_idx]   = 1'b0;
      dok_d[tail_idx]   = 1'b0;
      tail_d            = tail_q + PTR_W'(1);
    end
    if (flush_i) begin
      valid_d = '0;
      head_d  = '0;
      tail_d  = '0;
      aw_v_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      valid_q <= '0;
      aok_q   <= '0;
      dok_q   <= '0;
      aw_v_q  <= 1'b0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      valid_q <= valid_d;
      aok_q   <= aok_d;
      dok_q   <= dok_d;
      aw_v_q  <= aw_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (aw_valid_i) begin
      aw_idx_q  <= aw_idx_i;
      aw_vdw_q  <= aw_vaddr_i[VA_W-1:3];
      aw_pdw_q  <= aw_paddr_i[PA_W-1:3];
      aw_mask_q <= lane_mask(aw_size_i, aw_paddr_i[2:0]);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (aw_v_q && aw_idx_q == IDX_W'(i)) begin
        vdw_q[i]  <= aw_vdw_q;
        pdw_q[i]  <= aw_pdw_q;
        mask_q[i] <= aw_mask_q;
      end
      if (dw_valid_i && dw_idx_i == IDX_W'(i)) begin
        data_q[i] <= spread(dw_data_i, dw_size_i);
      end
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign valid_o = valid_q;
  assign aok_o   = aok_q;
  assign dok_o   = dok_q;
  assign vdw_o   = vdw_q;
  assign pdw_o   = pdw_q;
  assign mask_o  = mask_q;
  assign data_o  = data_q;

  assert_alloc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !flush_i && (tail_q - head_q) != PTR_W'(DEPTH)) |=> tail_q == PTR_W'($past(tail_q) + PTR_W'(1)));

  assert_occupancy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (PTR_W'(tail_q - head_q)) <= PTR_W'(DEPTH));

  assert_flush_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (head_q == '0) && (tail_q == '0) && (valid_q == '0));

endmodule

// File: rtl/stfwd_search.sv
module stfwd_search #(
  parameter int DEPTH = 8,
  parameter int VA_W  = 16,
  parameter int PA_W  = 20,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int VDW_W = VA_W - 3,
  localparam int PDW_W = PA_W - 3
) (
  input  logic [IDX_W-1:0]            head_idx_i,
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0]            aok_i,
  input  logic [DEPTH-1:0]            dok_i,
  input  logic [DEPTH-1:0][VDW_W-1:0] vdw_i,
  input  logic [DEPTH-1:0][PDW_W-1:0] pdw_i,
  input  logic [DEPTH-1:0][7:0]       mask_i,
  input  logic [DEPTH-1:0][63:0]      data_i,
  input  logic [VA_W-1:0]             ld_vaddr_i,
  input  logic [PA_W-1:0]             ld_paddr_i,
  input  logic [7:0]                  ld_mask_i,
  input  logic [DEPTH-1:0]            ld_older_i,
  output logic [7:0]                  hit_o,
  output logic [63:0]                 data_o,
  output logic                        dwait_o,
  output logic [IDX_W-1:0]            dwait_idx_o,
  output logic                        await_o,
  output logic [IDX_W-1:0]            await_idx_o,
  output logic                        mismatch_o
);

  logic [DEPTH-1:0] vmatch, pmatch, pending_addr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic live, overlap;
    assign live            = valid_i[i] && ld_older_i[i];
    assign overlap         = |(mask_i[i] & ld_mask_i);
    assign vmatch[i]       = live && aok_i[i] && overlap && (vdw_i[i] == ld_vaddr_i[VA_W-1:3]);
    assign pmatch[i]       = live && aok_i[i] && overlap && (pdw_i[i] == ld_paddr_i[PA_W-1:3]);
    assign pending_addr[i] = live && !aok_i[i];
  end

  // walk from oldest to youngest; a later (younger) entry overrides
  logic [IDX_W-1:0] e;
  always_comb begin
    hit_o       = '0;
    data_o      = '0;
    dwait_o     = 1'b0;
    dwait_idx_o = '0;
    await_o     = 1'b0;
    await_idx_o = '0;
    e           = '0;
    for (int k = 0; k < DEPTH; k++) begin
      e = head_idx_i + IDX_W'(k);
      if (vmatch[e] && !dok_i[e]) begin
        dwait_o     = 1'b1;
        dwait_idx_o = e;
      end
      if (pending_addr[e]) begin
        await_o     = 1'b1;
        await_idx_o = e;
      end
      for (int b = 0; b < 8; b++) begin
        if (vmatch[e] && mask_i[e][b] && ld_mask_i[b]) begin
          hit_o[b]        = dok_i[e];
          data_o[b*8 +: 8] = dok_i[e] ? data_i[e][b*8 +: 8] : 8'h00;
        end
      end
    end
  end

  assign mismatch_o = |(vmatch ^ pmatch);

endmodule

// File: rtl/stfwd_resp.sv
module stfwd_resp
  import stfwd_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid_i,
  input  logic [7:0]       ld_mask_i,
  input  logic [7:0]       hit_i,
  input  logic [63:0]      data_i,
  input  logic             dwait_i,
  input  logic [IDX_W-1:0] dwait_idx_i,
  input  logic             await_i,
  input  logic [IDX_W-1:0] await_idx_i,
  input  logic             mis_i,
  output logic             s1_valid_o,
  output logic [7:0]       s1_hit_o,
  output logic             s1_dwait_o,
  output logic             s2_valid_o,
  output logic [7:0]       s2_hit_o,
  output logic [63:0]      s2_data_o,
  output logic             s2_dwait_o,
  output logic [IDX_W-1:0] s2_dwait_idx_o,
  output logic             s2_await_o,
  output logic [IDX_W-1:0] s2_await_idx_o,
  output logic             s2_mis_o
);

  logic             s1_v_q, s2_v_q;
  logic [7:0]       s1_hit_q, s2_hit_q;
  logic [63:0]      s1_data_q, s2_data_q;
  logic             s1_dw_q, s2_dw_q, s1_aw_q, s2_aw_q, s1_mis_q, s2_mis_q;
  logic [IDX_W-1:0] s1_dwi_q, s2_dwi_q, s1_awi_q, s2_awi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0;
      s2_v_q <= 1'b0;
    end else begin
      s1_v_q <= ld_valid_i;
      s2_v_q <= s1_v_q;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid_i) begin
      s1_hit_q  <= hit_i;
      s1_data_q <= data_i;
      s1_dw_q   <= dwait_i;
      s1_dwi_q  <= dwait_idx_i;
      s1_aw_q   <= await_i;
      s1_awi_q  <= await_idx_i;
      s1_mis_q  <= mis_i;
    end
    if (s1_v_q) begin
      s2_hit_q  <= s1_hit_q;
      s2_data_q <= s1_data_q;
      s2_dw_q   <= s1_dw_q;
      s2_dwi_q  <= s1_dwi_q;
      s2_aw_q   <= s1_aw_q;
      s2_awi_q  <= s1_awi_q;
      s2_mis_q  <= s1_mis_q;
    end
  end

  assign s1_valid_o     = s1_v_q;
  assign s1_hit_o       = s1_hit_q;
  assign s1_dwait_o     = s1_dw_q;
  assign s2_valid_o     = s2_v_q;
  assign s2_hit_o       = s2_hit_q;
  assign s2_data_o      = s2_data_q;
  assign s2_dwait_o     = s2_dw_q;
  assign s2_dwait_idx_o = s2_dwi_q;
  assign s2_await_o     = s2_aw_q;
  assign s2_await_idx_o = s2_awi_q;
  assign s2_mis_o       = s2_mis_q;

  assert_s1_lanes_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v_q |-> ((s1_hit_q & ~$past(ld_mask_i)) == 8'h00));

  assert_s2_unhit_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v_q |-> ((s2_data_q & ~lanes_to_bits(s2_hit_q)) == 64'h0));

  assert_dwait_both_stages_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v_q && s2_dw_q) |-> $past(s1_dw_q));

endmodule

// File: rtl/stfwd_queue.sv
module stfwd_queue
  import stfwd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int VA_W  = 16,
  parameter int PA_W  = 20,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int VDW_W = VA_W - 3,
  localparam int PDW_W = PA_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             alloc_i,
  input  logic             deq_i,
  output logic [PTR_W-1:0] head_ptr_o,
  output logic [PTR_W-1:0] tail_ptr_o,
  input  logic             aw_valid_i,
  input  logic [IDX_W-1:0] aw_idx_i,
  input  logic [VA_W-1:0]  aw_vaddr_i,
  input  logic [PA_W-1:0]  aw_paddr_i,
  input  logic [1:0]       aw_size_i,
  input  logic             dw_valid_i,
  input  logic [IDX_W-1:0] dw_idx_i,
  input  logic [63:0]      dw_data_i,
  input  logic [1:0]       dw_size_i,
  input  logic             ld_valid_i,
  input  logic [VA_W-1:0]  ld_vaddr_i,
  input  logic [PA_W-1:0]  ld_paddr_i,
  input  logic [7:0]       ld_mask_i,
  input  logic [DEPTH-1:0] ld_older_i,
  output logic             s1_valid_o,
  output logic [7:0]       s1_hit_o,
  output logic             s1_data_wait_o,
  output logic             s2_valid_o,
  output logic [7:0]       s2_hit_o,
  output logic [63:0]      s2_data_o,
  output logic             s2_data_wait_o,
  output logic [IDX_W-1:0] s2_data_wait_idx_o,
  output logic             s2_addr_wait_o,
  output logic [IDX_W-1:0] s2_addr_wait_idx_o,
  output logic             s2_mismatch_o
);

  logic [PTR_W-1:0]            head, tail;
  logic [DEPTH-1:0]            e_valid, e_aok, e_dok;
  logic [DEPTH-1:0][VDW_W-1:0] e_vdw;
  logic [DEPTH-1:0][PDW_W-1:0] e_pdw;
  logic [DEPTH-1:0][7:0]       e_mask;
  logic [DEPTH-1:0][63:0]      e_data;

  logic [7:0]       sr_hit;
  logic [63:0]      sr_data;
  logic             sr_dw, sr_aw, sr_mis;
  logic [IDX_W-1:0] sr_dwi, sr_awi;

  stfwd_entries #(.DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W)) entries_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .alloc_i    (alloc_i),
    .deq_i      (deq_i),
    .aw_valid_i (aw_valid_i),
    .aw_idx_i   (aw_idx_i),
    .aw_vaddr_i (aw_vaddr_i),
    .aw_paddr_i (aw_paddr_i),
    .aw_size_i  (aw_size_i),
    .dw_valid_i (dw_valid_i),
    .dw_idx_i   (dw_idx_i),
    .dw_data_i  (dw_data_i),
    .dw_size_i  (dw_size_i),
    .head_o     (head),
    .tail_o     (tail),
    .valid_o    (e_valid),
    .aok_o      (e_aok),
    .dok_o      (e_dok),
    .vdw_o      (e_vdw),
    .pdw_o      (e_pdw),
    .mask_o     (e_mask),
    .data_o     (e_data)
  );

  stfwd_search #(.DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W)) search_i (
    .head_idx_i  (head[IDX_W-1:0]),
    .valid_i     (e_valid),
    .aok_i       (e_aok),
    .dok_i       (e_dok),
    .vdw_i       (e_vdw),
    .pdw_i       (e_pdw),
    .mask_i      (e_mask),
    .data_i      (e_data),
    .ld_vaddr_i  (ld_vaddr_i),
    .ld_paddr_i  (ld_paddr_i),
    .ld_mask_i   (ld_mask_i),
    .ld_older_i  (ld_older_i),
    .hit_o       (sr_hit),
    .data_o      (sr_data),
    .dwait_o     (sr_dw),
    .dwait_idx_o (sr_dwi),
    .await_o     (sr_aw),
    .await_idx_o (sr_awi),
    .mismatch_o  (sr_mis)
  );

  stfwd_resp #(.IDX_W(IDX_W)) resp_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ld_valid_i     (ld_valid_i),
    .ld_mask_i      (ld_mask_i),
    .hit_i          (sr_hit),
    .data_i         (sr_data),
    .dwait_i        (sr_dw),
    .dwait_idx_i    (sr_dwi),
    .await_i        (sr_aw),
    .await_idx_i    (sr_awi),
    .mis_i          (sr_mis),
    .s1_valid_o     (s1_valid_o),
    .s1_hit_o       (s1_hit_o),
    .s1_dwait_o     (s1_data_wait_o),
    .s2_valid_o     (s2_valid_o),
    .s2_hit_o       (s2_hit_o),
    .s2_data_o      (s2_data_o),
    .s2_dwait_o     (s2_data_wait_o),
    .s2_dwait_idx_o (s2_data_wait_idx_o),
    .s2_await_o     (s2_addr_wait_o),
    .s2_await_idx_o (s2_addr_wait_idx_o),
    .s2_mis_o       (s2_mismatch_o)
  );

  assign head_ptr_o = head;
  assign tail_ptr_o = tail;

endmodule

// File: tb/stfwd_queue_tb.sv
module stfwd_queue_tb_top;

  localparam int DEPTH = 8;
  localparam int VA_W  = 16;
  localparam int PA_W  = 20;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam int VDW_W = VA_W - 3;
  localparam int PDW_W = PA_W - 3;
  localparam int NCYC  = 4000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, flush, alloc, deq;
  logic             aw_v, dw_v, ld_v;
  logic [IDX_W-1:0] aw_idx, dw_idx;
  logic [VA_W-1:0]  aw_va, ld_va;
  logic [PA_W-1:0]  aw_pa, ld_pa;
  logic [1:0]       aw_sz, dw_sz;
  logic [63:0]      dw_d;
  logic [7:0]       ld_m;
  logic [DEPTH-1:0] ld_old;
  logic [PTR_W-1:0] head_o, tail_o;
  logic             s1_v, s1_dw, s2_v, s2_dw, s2_aw, s2_mis;
  logic [7:0]       s1_hit, s2_hit;
  logic [63:0]      s2_data;
  logic [IDX_W-1:0] s2_dwi, s2_awi;

  stfwd_queue #(.DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .alloc_i(alloc), .deq_i(deq),
    .head_ptr_o(head_o), .tail_ptr_o(tail_o),
    .aw_valid_i(aw_v), .aw_idx_i(aw_idx), .aw_vaddr_i(aw_va), .aw_paddr_i(aw_pa), .aw_size_i(aw_sz),
    .dw_valid_i(dw_v), .dw_idx_i(dw_idx), .dw_data_i(dw_d), .dw_size_i(dw_sz),
    .ld_valid_i(ld_v), .ld_vaddr_i(ld_va), .ld_paddr_i(ld_pa), .ld_mask_i(ld_m), .ld_older_i(ld_old),
    .s1_valid_o(s1_v), .s1_hit_o(s1_hit), .s1_data_wait_o(s1_dw),
    .s2_valid_o(s2_v), .s2_hit_o(s2_hit), .s2_data_o(s2_data), .s2_data_wait_o(s2_dw),
    .s2_data_wait_idx_o(s2_dwi), .s2_addr_wait_o(s2_aw), .s2_addr_wait_idx_o(s2_awi),
    .s2_mismatch_o(s2_mis)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: state the design holds before the coming edge
  bit               m_valid[DEPTH], m_aok[DEPTH], m_dok[DEPTH];
  logic [VDW_W-1:0] m_vdw[DEPTH];
  logic [PDW_W-1:0] m_pdw[DEPTH];
  logic [7:0]       m_mask[DEPTH];
  logic [63:0]      m_data[DEPTH];
  int               m_head, m_tail;
  bit               p_v;
  int               p_idx;
  logic [VDW_W-1:0] p_vdw;
  logic [PDW_W-1:0] p_pdw;
  logic [7:0]       p_mask;

  // expectation delay line: slot 1 due next falling edge, slot 2 the one after
  bit          e1_v, e2_v, n_dw, n_aw, n_mis, e1_dw, e1_aw, e1_mis, e2_dw, e2_aw, e2_mis;
  logic [7:0]  n_hit, e1_hit, e2_hit;
  logic [63:0] n_data, e1_data, e2_data;
  int          n_dwi, n_awi, e1_dwi, e1_awi, e2_dwi, e2_awi;

  function automatic logic [7:0] ref_mask(input int sz, input int off);
    int n = 1 << sz;
    logic [15:0] m = 16'((1 << n) - 1) << off;
    return m[7:0];
  endfunction

  function automatic logic [63:0] ref_spread(input logic [63:0] d, input int sz);
    logic [63:0] r;
    int n = 1 << sz;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = d[(b % n)*8 +: 8];
    return r;
  endfunction

  function automatic int occupancy();
    return (m_tail - m_head + 2*DEPTH) % (2*DEPTH);
  endfunction

  task automatic predict(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                         input logic [7:0] lm, input logic [DEPTH-1:0] old);
    n_hit = '0; n_data = '0; n_dw = 0; n_dwi = 0; n_aw = 0; n_awi = 0; n_mis = 0;
    for (int k = 0; k < DEPTH; k++) begin
      int  e = (m_head + k) % DEPTH;
      bit  live = m_valid[e] && old[e];
      bit  ov = (m_mask[e] & lm) != 0;
      bit  vm = live && m_aok[e] && ov && (m_vdw[e] == va[VA_W-1:3]);
      bit  pm = live && m_aok[e] && ov && (m_pdw[e] == pa[PA_W-1:3]);
      if (vm != pm) n_mis = 1;
      if (vm && !m_dok[e]) begin n_dw = 1; n_dwi = e; end
      if (live && !m_aok[e]) begin n_aw = 1; n_awi = e; end
      for (int b = 0; b < 8; b++)
        if (vm && m_mask[e][b] && lm[b]) begin
          n_hit[b] = m_dok[e];
          n_data[b*8 +: 8] = m_dok[e] ? m_data[e][b*8 +: 8] : 8'h00;
        end
    end
  endtask

  task automatic gen_addr(output logic [VA_W-1:0] va, output logic [PA_W-1:0] pa, input int off);
    logic [VDW_W-1:0] vd = VDW_W'(16 + $urandom % 3);
    logic [PDW_W-1:0] pd = PDW_W'(vd) + PDW_W'(17'h400) + PDW_W'(($urandom % 12 == 0) ? 1 : 0);
    va = {vd, 3'(off)};
    pa = {pd, 3'(off)};
  endtask

  task automatic check_outputs();
    chk(head_o == PTR_W'(m_head), "R2 R3 head pointer", 64'(head_o), 64'(m_head));
    chk(tail_o == PTR_W'(m_tail), "R2 R3 tail pointer", 64'(tail_o), 64'(m_tail));
    chk(s1_v == e1_v, "R6 s1 valid", 64'(s1_v), 64'(e1_v));
    chk(s2_v == e2_v, "R7 s2 valid", 64'(s2_v), 64'(e2_v));
    if (e1_v) begin
      chk(s1_hit == e1_hit, "R4 R6 R8 s1 hit mask", 64'(s1_hit), 64'(e1_hit));
      chk(s1_dw == e1_dw, "R9 s1 data wait", 64'(s1_dw), 64'(e1_dw));
    end
    if (e2_v) begin
      chk(s2_hit == e2_hit, "R7 R8 s2 hit mask", 64'(s2_hit), 64'(e2_hit));
      chk(s2_data == e2_data, "R5 R7 s2 data", s2_data, e2_data);
      chk(s2_dw == e2_dw, "R9 s2 data wait", 64'(s2_dw), 64'(e2_dw));
      chk(s2_dwi == IDX_W'(e2_dwi), "R9 data wait index", 64'(s2_dwi), 64'(e2_dwi));
      chk(s2_aw == e2_aw, "R10 addr wait", 64'(s2_aw), 64'(e2_aw));
      chk(s2_awi == IDX_W'(e2_awi), "R10 addr wait index", 64'(s2_awi), 64'(e2_awi));
      chk(s2_mis == e2_mis, "R11 mismatch", 64'(s2_mis), 64'(e2_mis));
    end
  endtask

  task automatic step();
    int occ = occupancy();
    int h = m_head % DEPTH;
    int cand[$];
    int sz, off, j;
    check_outputs();
    e2_v = e1_v; e2_hit = e1_hit; e2_data = e1_data; e2_dw = e1_dw; e2_dwi = e1_dwi;
    e2_aw = e1_aw; e2_awi = e1_awi; e2_mis = e1_mis;

    flush = ($urandom % 64 == 0);
    alloc = ($urandom % 2 == 0);
    deq   = (occ == 0) ? ($urandom % 8 == 0)
          : (m_aok[h] && m_dok[h] && !(p_v && p_idx == h) && ($urandom % 3 == 0));

    cand.delete();
    for (int e = 0; e < DEPTH; e++)
      if (m_valid[e] && !m_aok[e] && !(p_v && p_idx == e)) cand.push_back(e);
    aw_v = (cand.size() > 0) && ($urandom % 2 == 0);
    if (aw_v) begin
      aw_idx = IDX_W'(cand[$urandom % cand.size()]);
      sz = $urandom % 4; off = ($urandom % 8) & ~((1 << sz) - 1);
      aw_sz = 2'(sz);
      gen_addr(aw_va, aw_pa, off);
    end

    cand.delete();
    for (int e = 0; e < DEPTH; e++)
      if (m_valid[e] && !m_dok[e]) cand.push_back(e);
    dw_v = (cand.size() > 0) && ($urandom % 2 == 0);
    if (dw_v) begin
      dw_idx = IDX_W'(cand[$urandom % cand.size()]);
      dw_sz = 2'($urandom % 4);
      dw_d = {$urandom, $urandom};
    end

    ld_v = ($urandom % 4 != 0);
    gen_addr(ld_va, ld_pa, $urandom % 8);
    case ($urandom % 3)
      0: ld_m = 8'h01 << ($urandom % 8);
      1: ld_m = 8'hff;
      default: ld_m = 8'($urandom) | 8'h01;
    endcase
    ld_old = '0;
    j = $urandom % (occ + 1);
    for (int k = 0; k < j; k++) ld_old[(m_head + k) % DEPTH] = 1'b1;

    e1_v = ld_v;
    if (ld_v) begin
      predict(ld_va, ld_pa, ld_m, ld_old);
      e1_hit = n_hit; e1_data = n_data; e1_dw = n_dw; e1_dwi = n_dwi;
      e1_aw = n_aw; e1_awi = n_awi; e1_mis = n_mis;
    end

    // model update for the coming edge
    if (p_v) begin
      m_aok[p_idx] = 1; m_vdw[p_idx] = p_vdw; m_pdw[p_idx] = p_pdw; m_mask[p_idx] = p_mask;
    end
    if (dw_v) begin
      m_dok[dw_idx] = 1; m_data[dw_idx] = ref_spread(dw_d, int'(dw_sz));
    end
    if (deq && occ > 0) begin
      m_valid[h] = 0; m_head = (m_head + 1) % (2*DEPTH);
    end
    if (alloc && occ < DEPTH) begin
      m_valid[m_tail % DEPTH] = 1; m_aok[m_tail % DEPTH] = 0; m_dok[m_tail % DEPTH] = 0;
      m_tail = (m_tail + 1) % (2*DEPTH);
    end
    p_v = aw_v;
    if (aw_v) begin
      p_idx = int'(aw_idx); p_vdw = aw_va[VA_W-1:3]; p_pdw = aw_pa[PA_W-1:3];
      p_mask = ref_mask(int'(aw_sz), int'(aw_pa[2:0]));
    end
    if (flush) begin
      for (int e = 0; e < DEPTH; e++) m_valid[e] = 0;
      m_head = 0; m_tail = 0; p_v = 0;
    end
  endtask

  initial begin
    rst_n = 1'b0; flush = 0; alloc = 0; deq = 0; aw_v = 0; dw_v = 0; ld_v = 0;
    aw_idx = '0; aw_va = '0; aw_pa = '0; aw_sz = '0; dw_idx = '0; dw_d = '0; dw_sz = '0;
    ld_va = '0; ld_pa = '0; ld_m = '0; ld_old = '0;
    m_head = 0; m_tail = 0; p_v = 0; e1_v = 0; e2_v = 0;
    for (int e = 0; e < DEPTH; e++) begin
      m_valid[e] = 0; m_aok[e] = 0; m_dok[e] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(head_o == '0 && tail_o == '0, "R1 pointers in reset", 64'({head_o, tail_o}), 64'h0);
    chk(!s1_v && !s2_v, "R1 response valids in reset", 64'({s1_v, s2_v}), 64'h0);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      step();
    end
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired R1 act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule